// File: doc/BRIEF.md
# Dual-Output PWM Timer Channel

One timer channel with a 16-bit up-counter that drives two pulse-width-modulated pins. Both pins share one clock prescaler and one clock/clear control word. Each pin has its own period and duty compare pair. The counter clears itself when it matches the period register of the pin that was chosen as the clear source. That pin sets the cycle length, and the other pin follows with its own duty threshold.

A small register port writes the control word, the four compare registers and the two pin enables. A separate read port returns every register, a status word and the live counter value. A pin that is not enabled has its output enable low. The counter runs while either pin is enabled. While it runs the control word is locked: a write to it is dropped and a sticky error flag is raised.

Top module: `pwm_dual_chan`

## Requirements
- R1: After reset the counter reads 0, all four compare registers read 0xFFFF, the control word reads 0, both enables are 0, the status word is 0, and both pins have output enable low and level low.
- R2: The address map is: 0 control (bits 1:0 prescale code, bit 2 clear select), 1 period of pin 0, 2 duty of pin 0, 3 period of pin 1, 4 duty of pin 1, and 5 enables (bit 0 pin 0, bit 1 pin 1). Address 6 is the read-only status word (bit 0 counter running, bit 1 sticky error). Address 7 is the read-only counter. Every writable field reads back what was last accepted.
- R3: A prescale code k makes the counter advance once every 4^k input clocks (1, 4, 16 or 64).
- R4: Clear select 0 makes the counter wrap to 0 after it matches the pin-0 period. Clear select 1 uses the pin-1 period instead. With period P, the cycle lasts (P+1)·4^k clocks.
- R5: An enabled pin with duty D, where 0 < D < its period, is high while the counter is below D and low otherwise. It therefore goes high when the counter wraps.
- R6: A duty of 0 keeps an enabled pin low. A duty greater than or equal to its period keeps it high.
- R7: Each pin's output enable equals its enable bit. A disabled pin is driven low behind that low enable.
- R8: The counter runs while either enable is set. When both are clear, the counter and prescaler return to 0 on the next clock.
- R9: A control write while the counter runs leaves the control word unchanged and sets the error flag. The flag stays set until reset.
- R10: From one clock to the next, the counter either holds, steps up by one, or returns to 0.
- R11: Compare register writes take effect on the next clock, whether the counter is stopped or running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address |
| wr_data_i | input | 16 | Write data |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 16 | Read data for rd_addr_i, combinational |
| pwm_o | output | 2 | Pin levels |
| pwm_oe_o | output | 2 | Pin output enables; low means high impedance |

## Verification
The hardest state to reach is the one where the counter is cleared by one pin's period while the other pin's own period is larger, smaller or rewritten mid-cycle. In that state the second pin's duty is checked against a count that never reaches its own period. Directed steps select the pin-1 period as the clear source while both pins run. A long random phase then rewrites compare registers, enables and locked control words at random times with small periods. This places matches, wraps and stopped-counter restarts in many phases. Every cycle is compared against a bench model of the counter, the prescaler and the pins.

// File: rtl/pwm_dual_pkg.sv
`timescale 1ns/1ps
package pwm_dual_pkg;
  localparam int CNT_W_DEF = 16;
  localparam int PSC_W_DEF = 2;
  localparam int N_OUT     = 2;
  localparam int N_CMP     = 2 * N_OUT;
  localparam int ADDR_W    = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADR_CTRL = 3'd0,
    ADR_PER0 = 3'd1,
    ADR_DUT0 = 3'd2,
    ADR_PER1 = 3'd3,
    ADR_DUT1 = 3'd4,
    ADR_EN   = 3'd5,
    ADR_STAT = 3'd6,
    ADR_CNT  = 3'd7
  } addr_e;
endpackage

// File: rtl/pwm_dual_regs.sv
`timescale 1ns/1ps
module pwm_dual_regs
  import pwm_dual_pkg::*;
#(
  parameter int CNT_W = CNT_W_DEF,
  parameter int PSC_W = PSC_W_DEF
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [ADDR_W-1:0]           wr_addr_i,
  input  logic [CNT_W-1:0]            wr_data_i,
  output logic [PSC_W-1:0]            psc_o,
  output logic                        clr_sel_o,
  output logic [N_CMP-1:0][CNT_W-1:0] cmp_o,
  output logic [N_OUT-1:0]            en_o,
  output logic                        err_o
);
  logic running;
  assign running = |en_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psc_o     <= '0;
      clr_sel_o <= 1'b0;
      cmp_o     <= '1;
      en_o      <= '0;
      err_o     <= 1'b0;
    end else if (wr_en_i) begin
      unique case (addr_e'(wr_addr_i))
        ADR_CTRL: begin
          // clock/clear word locked while counting
          if (running) err_o <= 1'b1;
          else {clr_sel_o, psc_o} <= wr_data_i[PSC_W:0];
        end
        ADR_PER0: cmp_o[0] <= wr_data_i;
        ADR_DUT0: cmp_o[1] <= wr_data_i;
        ADR_PER1: cmp_o[2] <= wr_data_i;
        ADR_DUT1: cmp_o[3] <= wr_data_i;
        ADR_EN:   en_o     <= wr_data_i[N_OUT-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pwm_prescaler.sv
`timescale 1ns/1ps
module pwm_prescaler #(
  parameter int PSC_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [PSC_W-1:0] code_i,
  output logic             tick_o
);
  // ratio 4^k, largest code needs 2*(2^PSC_W-1) bits
  localparam int DIV_W = 2 * ((1 << PSC_W) - 1);

  logic [DIV_W-1:0] div_q, lim;

  always_comb begin
    lim = '0;
    for (int b = 0; b < DIV_W; b++) lim[b] = (b < 2 * int'(code_i));
  end

  assign tick_o = run_i && (div_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        div_q <= '0;
    else if (!run_i)    div_q <= '0;
    else if (tick_o)    div_q <= '0;
    else                div_q <= div_q + DIV_W'(1);
  end
endmodule

// File: rtl/pwm_counter.sv
`timescale 1ns/1ps
module pwm_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_o <= '0;
    else if (!run_i)  cnt_o <= '0;
    else if (tick_i)  cnt_o <= (cnt_o == period_i) ? '0 : cnt_o + CNT_W'(1);
  end
endmodule

// File: rtl/pwm_out_stage.sv
`timescale 1ns/1ps
module pwm_out_stage #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic             en_i,
  output logic             pwm_o,
  output logic             oe_o
);
  logic level;

  always_comb begin
    if (duty_i == '0)            level = 1'b0;
    else if (duty_i >= period_i) level = 1'b1;
    else                         level = (cnt_i < duty_i);
  end

  assign pwm_o = en_i & level;
  assign oe_o  = en_i;
endmodule

// File: rtl/pwm_dual_chan.sv
`timescale 1ns/1ps
module pwm_dual_chan
  import pwm_dual_pkg::*;
#(
  parameter int CNT_W = CNT_W_DEF,
  parameter int PSC_W = PSC_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [CNT_W-1:0]  rd_data_o,
  output logic [N_OUT-1:0]  pwm_o,
  output logic [N_OUT-1:0]  pwm_oe_o
);
  logic [PSC_W-1:0]            psc;
  logic                        clr_sel;
  logic [N_CMP-1:0][CNT_W-1:0] cmp;
  logic [N_OUT-1:0]            en;
  logic                        err;
  logic                        running;
  logic                        tick;
  logic [CNT_W-1:0]            cnt;
  logic [CNT_W-1:0]            clr_period;

  assign running    = |en;
  assign clr_period = clr_sel ? cmp[2] : cmp[0];

  pwm_dual_regs #(.CNT_W(CNT_W), .PSC_W(PSC_W)) i_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .psc_o(psc), .clr_sel_o(clr_sel), .cmp_o(cmp), .en_o(en), .err_o(err)
  );

  pwm_prescaler #(.PSC_W(PSC_W)) i_psc (
    .clk_i, .rst_ni, .run_i(running), .code_i(psc), .tick_o(tick)
  );

  pwm_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk_i, .rst_ni, .run_i(running), .tick_i(tick),
    .period_i(clr_period), .cnt_o(cnt)
  );

  for (genvar g = 0; g < N_OUT; g++) begin : g_out
    pwm_out_stage #(.CNT_W(CNT_W)) i_out (
      .cnt_i(cnt), .period_i(cmp[2*g]), .duty_i(cmp[2*g+1]),
      .en_i(en[g]), .pwm_o(pwm_o[g]), .oe_o(pwm_oe_o[g])
    );
  end

  always_comb begin
    unique case (addr_e'(rd_addr_i))
      ADR_CTRL: rd_data_o = {{(CNT_W-PSC_W-1){1'b0}}, clr_sel, psc};
      ADR_PER0: rd_data_o = cmp[0];
      ADR_DUT0: rd_data_o = cmp[1];
      ADR_PER1: rd_data_o = cmp[2];
      ADR_DUT1: rd_data_o = cmp[3];
      ADR_EN:   rd_data_o = {{(CNT_W-N_OUT){1'b0}}, en};
      ADR_STAT: rd_data_o = {{(CNT_W-2){1'b0}}, err, running};
      ADR_CNT:  rd_data_o = cnt;
      default:  rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/pwm_dual_chan_chk.sv
`timescale 1ns/1ps
module pwm_dual_chan_chk
  import pwm_dual_pkg::*;
#(
  parameter int CNT_W = CNT_W_DEF,
  parameter int PSC_W = PSC_W_DEF
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [N_OUT-1:0]  en,
  input logic [CNT_W-1:0]  cnt,
  input logic              err,
  input logic [PSC_W:0]    ctrl,
  input logic [N_OUT-1:0]  pwm_o,
  input logic [N_OUT-1:0]  pwm_oe_o
);
  assert_pin_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_o & ~pwm_oe_o) == '0);

  assert_oe_is_enable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwm_oe_o == en);

  assert_stop_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|en) |=> (cnt == '0));

  assert_ctrl_locked_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == ADR_CTRL && (|en)) |=> (err && $stable(ctrl)));

  assert_err_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err |=> err);

  assert_cnt_step_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt != $past(cnt)) |-> (cnt == '0 || cnt == $past(cnt) + CNT_W'(1)));
endmodule

bind pwm_dual_chan pwm_dual_chan_chk #(.CNT_W(CNT_W), .PSC_W(PSC_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .en(en), .cnt(cnt), .err(err), .ctrl({clr_sel, psc}),
  .pwm_o(pwm_o), .pwm_oe_o(pwm_oe_o)
);

// File: tb/test_pwm_dual_chan.sv
`timescale 1ns/1ps
module test_pwm_dual_chan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [1:0]  pwm, oe;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  bit cmp_on = 1'b0;

  always #10 clk = ~clk;

  pwm_dual_chan i_pwm_dual_chan (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .pwm_o(pwm), .pwm_oe_o(oe)
  );

  // bench model from the requirements
  logic [15:0] m_cmp [4];
  logic [1:0]  m_psc;
  logic        m_sel;
  logic [1:0]  m_en;
  logic        m_err;
  logic [15:0] m_cnt;
  int          m_div;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) m_cmp[i] <= 16'hFFFF;
      m_psc <= 0; m_sel <= 0; m_en <= 0; m_err <= 0; m_cnt <= 0; m_div <= 0;
    end else begin
      if (m_en == 0) begin
        m_cnt <= 0; m_div <= 0;
      end else if (m_div == (4 ** m_psc) - 1) begin
        m_div <= 0;
        m_cnt <= (m_cnt == (m_sel ? m_cmp[2] : m_cmp[0])) ? 16'd0 : m_cnt + 16'd1;
      end else m_div <= m_div + 1;
      if (wr_en) begin
        case (wr_addr)
          3'd0: if (m_en != 0) m_err <= 1; else begin m_psc <= wr_data[1:0]; m_sel <= wr_data[2]; end
          3'd1, 3'd2, 3'd3, 3'd4: m_cmp[wr_addr-1] <= wr_data;
          3'd5: m_en <= wr_data[1:0];
          default: ;
        endcase
      end
    end
  end

  function automatic logic lvl(logic [15:0] c, logic [15:0] p, logic [15:0] d);
    if (d == 0) return 1'b0;
    if (d >= p) return 1'b1;
    return c < d;
  endfunction

  function automatic logic [15:0] exp_rd(logic [2:0] a);
    case (a)
      3'd0: return {13'd0, m_sel, m_psc};
      3'd1, 3'd2, 3'd3, 3'd4: return m_cmp[a-1];
      3'd5: return {14'd0, m_en};
      3'd6: return {14'd0, m_err, m_en != 0};
      default: return m_cnt;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // lockstep comparison every cycle
  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      for (int i = 0; i < 2; i++) begin
        check("R5 pin level", pwm[i], m_en[i] & lvl(m_cnt, m_cmp[2*i], m_cmp[2*i+1]));
        check("R7 output enable", oe[i], m_en[i]);
      end
      check("R2 readback", rd_data, exp_rd(rd_addr));
    end
  end

  task automatic wr(logic [2:0] a, logic [15:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); #2;
    wr_en = 0;
  endtask

  task automatic idle(int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] v);
    rd_addr = a; #5; v = rd_data;
  endtask

  // clocks between two rises of a pin, and high clocks in that span
  task automatic measure(int i, output int per, output int high);
    logic prev = 1'b1;
    int n = 0;
    per = -1; high = 0;
    while (n < 3000 && !(pwm[i] && !prev)) begin prev = pwm[i]; @(negedge clk); n++; end
    per = 0;
    prev = 1'b1;
    while (n < 3000) begin
      if (pwm[i]) high++;
      per++;
      prev = pwm[i];
      @(negedge clk); n++;
      if (pwm[i] && !prev) break;
    end
    @(posedge clk); #2;
  endtask

  task automatic count_high(int i, int n, output int h);
    h = 0;
    repeat (n) begin @(negedge clk); if (pwm[i]) h++; end
    @(posedge clk); #2;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_up();
  end

  initial begin
    logic [15:0] v;
    int per, high;
    void'($urandom(32'h5eed_1234));
    idle(3);
    rst_n = 1;
    idle(1);
    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0], v);
      check("R1 reset register", v, (a >= 1 && a <= 4) ? 16'hFFFF : 16'h0);
    end
    check("R1 reset pins", {oe, pwm}, 4'b0);
    idle(1);
    cmp_on = 1;

    // R2/R4/R5 pin 0, ratio 1, period 9 duty 3
    wr(3'd0, 16'h0000);
    wr(3'd1, 16'd9);
    wr(3'd2, 16'd3);
    rd(3'd1, v); check("R2 period0 readback", v, 16'd9);
    wr(3'd5, 16'h1);
    measure(0, per, high);
    check("R4 cycle length P+1", per, 10);
    check("R5 high clocks = duty", high, 3);

    // R8 stop clears counter
    wr(3'd5, 16'h0);
    idle(1);
    rd(3'd7, v); check("R8 counter cleared when stopped", v, 0);
    rd(3'd6, v); check("R8 status not running", v, 0);

    // R3 prescale code 2 -> 16 clocks per step
    wr(3'd0, 16'h0002);
    wr(3'd5, 16'h1);
    measure(0, per, high);
    check("R3 ratio 16 cycle", per, 160);
    check("R3 ratio 16 high", high, 48);

    // R9 locked control
    wr(3'd0, 16'h0000);
    rd(3'd0, v); check("R9 control unchanged", v, 16'h0002);
    rd(3'd6, v); check("R9 error flag set", v, 16'h0003);

    // R6 / R11 duty corners written while running
    wr(3'd0, 16'h0000); // still locked
    wr(3'd2, 16'd0);
    count_high(0, 200, high);
    check("R6 duty zero low", high, 0);
    wr(3'd2, 16'd12);
    count_high(0, 200, high);
    check("R6 duty above period high", high, 200);
    wr(3'd2, 16'd9);
    count_high(0, 50, high);
    check("R11 duty equal period high", high, 50);

    // R4 clear from pin-1 period, R7 second pin
    wr(3'd5, 16'h0);
    wr(3'd0, 16'h0004);
    rd(3'd0, v); check("R4 clear select accepted", v, 16'h0004);
    wr(3'd3, 16'd4);
    wr(3'd4, 16'd2);
    wr(3'd1, 16'd20);
    wr(3'd2, 16'd5);
    check("R7 pin1 idle oe", oe[1], 1'b0);
    wr(3'd5, 16'h3);
    measure(1, per, high);
    check("R4 pin1 period clears", per, 5);
    check("R5 pin1 high", high, 2);
    count_high(0, 40, high);
    check("R4 pin0 follows pin1 clear", high, 40);
    wr(3'd5, 16'h2);
    idle(1);
    check("R7 pin0 released", {oe[0], pwm[0]}, 2'b00);
    rd(3'd6, v); check("R8 one enable keeps running", v[0], 1'b1);

    // R10 counter step visible at readback
    rd(3'd7, v);
    begin
      logic [15:0] v2;
      @(posedge clk); #2;
      rd(3'd7, v2);
      check("R10 counter step", (v2 == v + 1) || (v2 == 0), 1);
    end

    // random phase
    for (int n = 0; n < 5000; n++) begin
      int r = $urandom_range(0, 99);
      rd_addr = 3'($urandom_range(0, 7));
      if (r < 12) begin
        logic [2:0] a = 3'($urandom_range(0, 5));
        logic [15:0] d;
        if (a == 0) d = 16'($urandom_range(0, 7));
        else if (a == 5) d = 16'($urandom_range(0, 3));
        else d = ($urandom_range(0, 20) == 0) ? 16'hFFFF : 16'($urandom_range(0, 24));
        wr_en = 1; wr_addr = a; wr_data = d;
      end else if (r < 15) begin
        wr_en = 1; wr_addr = 3'd5; wr_data = 16'h0;
      end
      @(posedge clk); #2;
      wr_en = 0;
    end
    cmp_on = 0;
    finish_up();
  end
endmodule